// File: doc/BRIEF.md
# Parallel-Flash FPGA Configuration Sequencer

The sequencer loads one or two downstream FPGAs from a byte-wide parallel flash and decides when the board may leave reset. After reset it waits for power-good and for every target to release its active-low INIT line. It then streams the primary image from the lower half of the flash. When the primary reports DONE, it looks at the secondary's DONE line. If that line is already high, the secondary is absent and its line is pulled up, so the sequencer declares the board configured. If the line is low, the sequencer streams the secondary image from the upper half of the flash until that DONE rises.

A download parser controls reprogramming through three single-cycle request pulses. A start request drops the ready output at once. An end request with no data written restores readiness without touching the targets. An end request with data written pulses PROGRAM low so the targets clear themselves, and the whole load sequence then runs again. A board reset that does not come from a download leaves the loaded targets alone. If an image reaches the maximum byte count without its DONE rising, the sequencer stops and raises an error flag.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, `config_done_o`=0, `prog_n_o`=1, `cfg_err_o`=0 and `flash_rd_o`=0. No flash read occurs while `pwr_good_i` is low, or while either bit of `init_n_i` is low.
- R2: The primary image is streamed first, with `cs_n_o[0]` low. Byte n comes from flash address n, and address bit 22 is 0. Each byte takes two clocks: `flash_rd_o` is high with the address in the first clock, and `cclk_o` is high with that byte on `cfg_data_o` in the second. The byte stays stable through the following clock.
- R3: When `done_i[0]` is seen high, the sequencer samples `done_i[1]`. If that line is high, `config_done_o` rises and no secondary byte and no upper-half read occurs.
- R4: If `done_i[1]` is low, the secondary image is streamed with `cs_n_o[1]` low. Byte n comes from address 2^22+n. No secondary byte is clocked before `done_i[0]` is high, and streaming continues until `done_i[1]` rises.
- R5: `config_done_o` is high only after every present target has reported DONE, and it is never high during a flash read.
- R6: When MAX_BYTES bytes of one image have been clocked without DONE, streaming stops. `cfg_err_o` then goes high and `config_done_o` stays low. Both hold until a download start, which clears `cfg_err_o` in the next cycle.
- R7: A pulse on `dl_start_i` makes `config_done_o` low in the next cycle. It stays low, with no flash read, until a download end.
- R8: A pulse on `dl_end_empty_i` after a start raises `config_done_o` in the next cycle, with no PROGRAM pulse and no flash read.
- R9: A pulse on `dl_end_data_i` after a start drives `prog_n_o` low for exactly PROG_LOW (16) cycles. The sequencer then waits for both INIT lines to be high and reruns the full load from the primary image.
- R10: Once configured, INIT pulses from the targets and end pulses without a preceding start have no effect. `config_done_o` stays high, `prog_n_o` stays high, and no flash read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Board supplies stable |
| init_n_i | input | 2 | Per-target INIT, low while the target clears its configuration memory |
| done_i | input | 2 | Per-target DONE; bit 1 reads high when the secondary is absent |
| dl_start_i | input | 1 | Download start request pulse |
| dl_end_data_i | input | 1 | Download end pulse, flash data written |
| dl_end_empty_i | input | 1 | Download end pulse, no data written |
| prog_n_o | output | 1 | Active-low PROGRAM to both targets |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_addr_o | output | 23 | Flash byte address |
| flash_data_i | input | 8 | Flash read data, valid in the strobe cycle |
| cclk_o | output | 1 | Configuration clock, high while the byte is valid |
| cfg_data_o | output | 8 | Configuration byte to the targets |
| cs_n_o | output | 2 | Per-target active-low select |
| config_done_o | output | 1 | All present targets configured |
| cfg_err_o | output | 1 | Image exceeded the maximum length |

## Verification
Several properties are checked on every cycle. The address half always matches the selected target, and a flash read never coincides with PROGRAM low or with readiness. Each read is followed by a configuration clock, and the byte holds after that clock. PROGRAM stays low until its timer expires, a start request always drops readiness, and the error flag holds until a start. Other behaviour needs the bench's target and flash models and is shown only by scenarios. These cover byte-exact image contents and lengths per target, skipping an absent secondary, the exact PROGRAM width, the wait on INIT after PROGRAM, timeout and recovery, and immunity to stray INIT pulses and unmatched end requests.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_INIT,
    ST_LOAD0,
    ST_CHECK1,
    ST_LOAD1,
    ST_READY,
    ST_DL_HOLD,
    ST_PROG,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       init_ready_i,
  input  logic [1:0] done_i,
  input  logic       dl_start_i,
  input  logic       dl_end_data_i,
  input  logic       dl_end_empty_i,
  input  logic       last_i,
  input  logic       expire_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (dl_start_i) begin
      state_d = ST_DL_HOLD;
    end else begin
      unique case (state_q)
        ST_WAIT_INIT: if (pwr_good_i && init_ready_i) state_d = ST_LOAD0;
        ST_LOAD0: begin
          if (done_i[0])   state_d = ST_CHECK1;
          else if (last_i) state_d = ST_FAIL;
        end
        ST_CHECK1: state_d = done_i[1] ? ST_READY : ST_LOAD1;
        ST_LOAD1: begin
          if (done_i[1])   state_d = ST_READY;
          else if (last_i) state_d = ST_FAIL;
        end
        ST_DL_HOLD: begin
          if (dl_end_data_i)       state_d = ST_PROG;
          else if (dl_end_empty_i) state_d = ST_READY;
        end
        ST_PROG:  if (expire_i) state_d = ST_WAIT_INIT;
        ST_READY: state_d = ST_READY;
        ST_FAIL:  state_d = ST_FAIL;
        default:  state_d = ST_WAIT_INIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT_INIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cfg_seq_stream.sv
module cfg_seq_stream #(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned MAX_BYTES = 2 ** 22,
  localparam int unsigned CNT_W    = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sel_i,
  input  logic [7:0]        flash_data_i,
  output logic              flash_rd_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              cclk_o,
  output logic [7:0]        data_o,
  output logic              last_o
);
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else if (!active_i) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) data_q <= flash_data_i;
      else          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign flash_rd_o   = active_i & ~phase_q;
  assign flash_addr_o = {sel_i, cnt_q};
  assign cclk_o       = active_i & phase_q;
  assign data_o       = data_q;
  assign last_o       = cclk_o && (cnt_q == CNT_W'(MAX_BYTES - 1));

  // R2
  rd_then_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |=> (cclk_o || !active_i));
  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> $stable(data_o));
endmodule

// File: rtl/cfg_seq_prog_timer.sv
module cfg_seq_prog_timer #(
  parameter int unsigned PROG_LOW = 16,
  localparam int unsigned CW      = $clog2(PROG_LOW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  assign expire_o = en_i && (cnt_q == CW'(PROG_LOW - 1));

  // R9
  prog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !expire_o) |=> en_i);
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned MAX_BYTES = 2 ** 22,
  parameter int unsigned PROG_LOW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [1:0]        init_n_i,
  input  logic [1:0]        done_i,
  input  logic              dl_start_i,
  input  logic              dl_end_data_i,
  input  logic              dl_end_empty_i,
  output logic              prog_n_o,
  output logic              flash_rd_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  input  logic [7:0]        flash_data_i,
  output logic              cclk_o,
  output logic [7:0]        cfg_data_o,
  output logic [1:0]        cs_n_o,
  output logic              config_done_o,
  output logic              cfg_err_o
);
  seq_state_e state;
  logic       last, expire, load0, load1;

  assign load0 = (state == ST_LOAD0);
  assign load1 = (state == ST_LOAD1);

  cfg_seq_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwr_good_i     (pwr_good_i),
    .init_ready_i   (&init_n_i),
    .done_i         (done_i),
    .dl_start_i     (dl_start_i),
    .dl_end_data_i  (dl_end_data_i),
    .dl_end_empty_i (dl_end_empty_i),
    .last_i         (last),
    .expire_i       (expire),
    .state_o        (state)
  );

  cfg_seq_stream #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_stream (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (load0 | load1),
    .sel_i        (load1),
    .flash_data_i (flash_data_i),
    .flash_rd_o   (flash_rd_o),
    .flash_addr_o (flash_addr_o),
    .cclk_o       (cclk_o),
    .data_o       (cfg_data_o),
    .last_o       (last)
  );

  cfg_seq_prog_timer #(.PROG_LOW(PROG_LOW)) u_prog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state == ST_PROG),
    .expire_o (expire)
  );

  assign cs_n_o        = {~load1, ~load0};
  assign prog_n_o      = (state != ST_PROG);
  assign config_done_o = (state == ST_READY);
  assign cfg_err_o     = (state == ST_FAIL);

  // R7
  dl_start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_start_i |=> !config_done_o);
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !dl_start_i) |=> cfg_err_o);
  // R4
  addr_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |-> ((flash_addr_o[ADDR_W-1] == cs_n_o[0]) && (cs_n_o[0] != cs_n_o[1])));
  // R5
  rd_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |-> (prog_n_o && !config_done_o));
endmodule

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;
  localparam int unsigned AW   = 23;
  localparam int unsigned MAXB = 64;
  localparam int unsigned PLOW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 1'b0, dl_start = 1'b0, dl_end_data = 1'b0, dl_end_empty = 1'b0;
  logic [1:0] init_n, done, cs_n;
  logic prog_n, flash_rd, cclk, config_done, cfg_err;
  logic [AW-1:0] flash_addr;
  logic [7:0] flash_data, cfg_data;

  always #5 clk = ~clk;

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return 8'(a * 23'd13 + (a >> 9)) ^ (a[AW-1] ? 8'hA5 : 8'h00);
  endfunction

  assign flash_data = fb(flash_addr);

  cfg_load_seq #(.ADDR_W(AW), .MAX_BYTES(MAXB), .PROG_LOW(PLOW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .init_n_i(init_n), .done_i(done),
    .dl_start_i(dl_start), .dl_end_data_i(dl_end_data), .dl_end_empty_i(dl_end_empty),
    .prog_n_o(prog_n), .flash_rd_o(flash_rd), .flash_addr_o(flash_addr),
    .flash_data_i(flash_data), .cclk_o(cclk), .cfg_data_o(cfg_data), .cs_n_o(cs_n),
    .config_done_o(config_done), .cfg_err_o(cfg_err)
  );

  // target and monitor models, all at negedge
  int len0 = 20, len1 = 30;
  bit present1 = 1'b1, init_force = 1'b1;
  bit dq0 = 1'b0, dq1 = 1'b0;
  int cnt0 = 0, cnt1 = 0, init_cnt = 0;
  int rd_total = 0, rd_hi = 0, rd_init_low = 0, prog_run = 0, last_pw = 0, prog_pulses = 0;
  int cd_bad = 0, bytes0 = 0, bytes1 = 0, mism = 0, early1 = 0;

  assign init_n = {2{!init_force && init_cnt == 0}};
  assign done   = {present1 ? dq1 : 1'b1, dq0};

  always @(negedge clk) begin
    if (rst_n) begin
      if (flash_rd) begin
        rd_total++;
        if (flash_addr[AW-1]) rd_hi++;
        if (init_n != 2'b11 || !pwr_good) rd_init_low++;
      end
      if (!prog_n) prog_run++;
      else if (prog_run != 0) begin last_pw = prog_run; prog_pulses++; prog_run = 0; end
      if (config_done && !(done[0] && done[1])) cd_bad++;
      if (!prog_n) begin
        cnt0 = 0; cnt1 = 0; dq0 = 1'b0; dq1 = 1'b0; init_cnt = 8;
      end else begin
        if (init_cnt > 0) init_cnt--;
        if (cclk && !cs_n[0]) begin
          if (cfg_data !== fb(AW'(cnt0))) mism++;
          bytes0++; cnt0++;
          if (cnt0 == len0) dq0 = 1'b1;
        end
        if (cclk && !cs_n[1]) begin
          if (!done[0]) early1++;
          if (cfg_data !== fb({1'b1, 22'(cnt1)})) mism++;
          bytes1++; cnt1++;
          if (cnt1 == len1) dq1 = 1'b1;
        end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: dl_start = 1'b1;
      1: dl_end_data = 1'b1;
      default: dl_end_empty = 1'b1;
    endcase
    @(negedge clk);
    dl_start = 1'b0; dl_end_data = 1'b0; dl_end_empty = 1'b0;
  endtask

  task automatic wait_cfg();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (config_done || cfg_err) break;
    end
  endtask

  // full load check against deltas
  task automatic check_load(input string tag);
    int b0, b1, m, rh, e, ri, cb;
    b0 = bytes0; b1 = bytes1; m = mism; rh = rd_hi; e = early1; ri = rd_init_low; cb = cd_bad;
    wait_cfg();
    check(config_done == 1'b1, {tag, " R5 configured"}, int'(config_done), 1);
    check(bytes0 - b0 == len0, {tag, " R2 primary bytes"}, bytes0 - b0, len0);
    check(bytes1 - b1 == (present1 ? len1 : 0), {tag, " R4 secondary bytes"}, bytes1 - b1,
          present1 ? len1 : 0);
    check(mism == m, {tag, " R2 R4 byte contents"}, mism - m, 0);
    check(early1 == e, {tag, " R4 order"}, early1 - e, 0);
    check(cd_bad == cb, {tag, " R5 early ready"}, cd_bad - cb, 0);
    check(rd_init_low == ri, {tag, " R1 read while not ready"}, rd_init_low - ri, 0);
    if (!present1) check(rd_hi == rh, {tag, " R3 no upper read"}, rd_hi - rh, 0);
  endtask

  task automatic reload_with_data(input string tag);
    int pp;
    pulse(0);
    pp = prog_pulses;
    pulse(1);
    check_load(tag);
    check(prog_pulses == pp + 1 && last_pw == PLOW, {tag, " R9 prog width"}, last_pw, PLOW);
  endtask

  initial begin
    int unsigned seed;
    int r0, pp, b0;
    seed = $urandom(32'd1357);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!config_done && prog_n && !cfg_err && !flash_rd, "R1 reset outputs",
          {config_done, prog_n, cfg_err, flash_rd}, 4'b0100);
    rst_n = 1'b1;
    init_force = 1'b0;
    r0 = rd_total;
    repeat (20) @(negedge clk);
    check(rd_total == r0, "R1 no read without power good", rd_total - r0, 0);
    init_force = 1'b1; pwr_good = 1'b1;
    repeat (20) @(negedge clk);
    check(rd_total == r0, "R1 no read with INIT low", rd_total - r0, 0);
    init_force = 1'b0;
    check_load("poweron");

    // R7 start drops ready next cycle, R8 empty end restores it
    pp = prog_pulses; r0 = rd_total;
    @(negedge clk); dl_start = 1'b1;
    @(negedge clk); dl_start = 1'b0;
    check(config_done == 1'b0, "R7 ready drop", int'(config_done), 0);
    repeat (10) @(negedge clk);
    check(config_done == 1'b0, "R7 ready held low", int'(config_done), 0);
    dl_end_empty = 1'b1;
    @(negedge clk); dl_end_empty = 1'b0;
    check(config_done == 1'b1, "R8 ready after empty end", int'(config_done), 1);
    check(prog_pulses == pp && rd_total == r0, "R8 no prog no read", rd_total - r0, 0);

    // R10 stray INIT and unmatched end pulses
    init_force = 1'b1;
    repeat (6) @(negedge clk);
    init_force = 1'b0;
    pulse(1);
    pulse(2);
    repeat (5) @(negedge clk);
    check(config_done && prog_n && rd_total == r0 && prog_pulses == pp, "R10 configured state kept",
          rd_total - r0, 0);

    // R9 reload with data, dual target
    len0 = 17; len1 = 41;
    reload_with_data("dual");

    // R3 absent secondary
    pulse(0);
    present1 = 1'b0; len0 = 9;
    pulse(1);
    check_load("absent");

    // constrained random reloads
    for (int it = 0; it < 6; it++) begin
      pulse(0);
      present1 = ($urandom % 2) == 1;
      len0 = 1 + int'($urandom % 50);
      len1 = 1 + int'($urandom % 50);
      pulse(1);
      check_load("random");
    end

    // R6 timeout, then recovery
    pulse(0);
    present1 = 1'b1; len0 = 1000;
    b0 = bytes0;
    pulse(1);
    wait_cfg();
    check(cfg_err == 1'b1 && config_done == 1'b0, "R6 error raised", int'(cfg_err), 1);
    check(bytes0 - b0 == MAXB, "R6 bytes before error", bytes0 - b0, MAXB);
    r0 = rd_total;
    repeat (20) @(negedge clk);
    check(rd_total == r0 && cfg_err, "R6 stopped and sticky", rd_total - r0, 0);
    @(negedge clk); dl_start = 1'b1;
    @(negedge clk); dl_start = 1'b0;
    check(cfg_err == 1'b0, "R6 cleared by start", int'(cfg_err), 0);
    len0 = 12; len1 = 5;
    pulse(1);
    check_load("recover");

    // R6 timeout on the secondary
    pulse(0);
    len0 = 3; len1 = 500;
    b0 = bytes1;
    pulse(1);
    wait_cfg();
    check(cfg_err && bytes1 - b0 == MAXB, "R6 secondary timeout", bytes1 - b0, MAXB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule